// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Violation Monitor

The monitor sits beside an asynchronous static RAM bus and watches its two chip selects (one active low, one active high), the write-enable and output-enable strobes, the address and the data. A free-running sample clock much faster than the bus drives it. Every bus pin passes through a two-flop synchronizer. The monitor then finds edges and times the gaps between them in sample-clock ticks. Each minimum-timing rule has a parameter threshold.

A write window exists only while all three write controls are active. It opens on whichever control arrives last and closes on whichever control leaves first. The write rules are measured from those two edges: pulse width, select-to-end, address setup, data setup and write recovery. Two further rules check the address: a minimum cycle time between address changes while the chip is selected, and any address change inside an open write window. Each violated rule sets its own sticky flag. The monitor also keeps the code of the first violation and counts completed writes and reads. Maximum access times and electrical levels are not checked.

Top module: `sram_timing_monitor`

## Requirements
- R1: After reset, all violation flags are 0, the first-violation valid bit is 0 and both completed-operation counts are 0.
- R2: The write window is the overlap of sel_n_i low, sel_i high and wr_en_n_i low, whichever control makes it. wr_count_o increments once each time the window closes.
- R3: Code 1 (flag bit 0), pulse width: the window closes after fewer than T_WP sampled ticks open.
- R4: Code 2 (flag bit 1), select to end: when the window closes, the chip has been selected (both selects active) for fewer than T_CW ticks.
- R5: Code 3 (flag bit 2), address setup: the window opens fewer than T_AS ticks after the last address change. A change in the opening tick counts as 0.
- R6: Code 4 (flag bit 3), data setup: when the window closes, the data has been stable for fewer than T_DW ticks. A change in the closing tick counts as 0.
- R7: Code 5 (flag bit 4), write recovery: the address changes with the window shut, fewer than T_WR ticks after the last window close. A change in the closing tick counts as 0.
- R8: Code 6 (flag bit 5), cycle time: the address changes while the chip is selected, fewer than T_RC ticks after the previous address change.
- R9: Code 7 (flag bit 6): the address changes while the write window is open and was already open in the previous tick.
- R10: Flags are sticky until clr_i is sampled high. A clear clears all flags and the first-violation record in the next cycle, and it wins over a violation detected in the same cycle.
- R11: first_code_o holds the code of the earliest violation since the last clear. Among violations detected in the same tick, the lowest code wins. first_valid_o is 1 exactly when any flag is set, and the code does not change while it is 1.
- R12: A read phase is both selects active with wr_en_n_i high and out_en_n_i low. rd_count_o increments once when a read phase ends, and reads raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of flags and first-violation record |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| wr_en_n_i | input | 1 | Write enable, active low |
| out_en_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus data |
| viol_o | output | 7 | Sticky flags; bit k is code k+1 |
| first_code_o | output | 3 | Code of first violation since clear |
| first_valid_o | output | 1 | first_code_o is meaningful |
| wr_count_o | output | CNT_W | Completed write windows |
| rd_count_o | output | CNT_W | Completed read phases |

## Verification
The assertions assume that clr_i comes from the sample-clock domain. They also assume the bus pins settle to one value within a tick, so each synchronized edge lands on exactly one sample. The stimulus drives every pin on the falling edge of the sample clock and holds it for whole ticks. A pause of many idle ticks separates each write pattern from the next, so the age counters of one pattern never affect another. Because every pin has the same synchronizer latency, tick distances set at the pins arrive unchanged at the rule logic. This lets the expected flags be computed straight from the distances in the stimulus.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
  localparam int NRULE = 7;

  typedef enum logic [2:0] {
    CODE_NONE = 3'd0,
    CODE_WP   = 3'd1,
    CODE_CW   = 3'd2,
    CODE_AS   = 3'd3,
    CODE_DW   = 3'd4,
    CODE_WR   = 3'd5,
    CODE_RC   = 3'd6,
    CODE_AW   = 3'd7
  } viol_code_e;
endpackage

// File: rtl/sram_mon_sync.sv
module sram_mon_sync #(
  parameter int unsigned    W   = 1,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sram_mon_age.sv
// Saturating tick counter: restart loads 1, en counts up.
module sram_mon_age #(
  parameter int unsigned W        = 8,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= RST_FULL ? MAX : '0;
    else if (restart_i)              cnt_q <= W'(1);
    else if (en_i && cnt_q != MAX)   cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sram_timing_monitor.sv
module sram_timing_monitor
  import sram_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TICK_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned T_WP   = 6,
  parameter int unsigned T_CW   = 6,
  parameter int unsigned T_AS   = 0,
  parameter int unsigned T_DW   = 3,
  parameter int unsigned T_WR   = 0,
  parameter int unsigned T_RC   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              wr_en_n_i,
  input  logic              out_en_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NRULE-1:0]  viol_o,
  output logic [2:0]        first_code_o,
  output logic              first_valid_o,
  output logic [CNT_W-1:0]  wr_count_o,
  output logic [CNT_W-1:0]  rd_count_o
);
  localparam logic [TICK_W-1:0] LIM_WP = TICK_W'(T_WP);
  localparam logic [TICK_W-1:0] LIM_CW = TICK_W'(T_CW);
  localparam logic [TICK_W-1:0] LIM_AS = TICK_W'(T_AS);
  localparam logic [TICK_W-1:0] LIM_DW = TICK_W'(T_DW);
  localparam logic [TICK_W-1:0] LIM_WR = TICK_W'(T_WR);
  localparam logic [TICK_W-1:0] LIM_RC = TICK_W'(T_RC);
  // age slots: 0 window, 1 select, 2 address, 3 data, 4 since window close
  localparam int unsigned  NAGE      = 5;
  localparam logic [4:0]   FULL_MASK = 5'b11100;

  function automatic logic below(input logic [TICK_W-1:0] v,
                                 input logic [TICK_W-1:0] lim);
    return v < lim;
  endfunction

  // synchronizers
  logic [3:0]        ctl_s;
  logic [ADDR_W-1:0] addr_s, addr_p;
  logic [DATA_W-1:0] data_s, data_p;

  sram_mon_sync #(.W(4), .RST(4'b1011)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({sel_n_i, sel_i, wr_en_n_i, out_en_n_i}), .q_o(ctl_s));
  sram_mon_sync #(.W(ADDR_W), .RST('0)) u_sync_addr (
    .clk_i, .rst_ni, .d_i(addr_i), .q_o(addr_s));
  sram_mon_sync #(.W(DATA_W), .RST('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s));

  logic sel, win, rd, sel_q, win_q, rd_q;
  assign sel = ~ctl_s[3] & ctl_s[2];
  assign win = sel & ~ctl_s[1];
  assign rd  = sel & ctl_s[1] & ~ctl_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      win_q  <= 1'b0;
      rd_q   <= 1'b0;
      addr_p <= '0;
      data_p <= '0;
    end else begin
      sel_q  <= sel;
      win_q  <= win;
      rd_q   <= rd;
      addr_p <= addr_s;
      data_p <= data_s;
    end
  end

  logic win_start, win_end, sel_rise, rd_end, addr_chg, data_chg;
  assign win_start = win & ~win_q;
  assign win_end   = ~win & win_q;
  assign sel_rise  = sel & ~sel_q;
  assign rd_end    = ~rd & rd_q;
  assign addr_chg  = addr_s != addr_p;
  assign data_chg  = data_s != data_p;

  // interval counters
  logic [NAGE-1:0]   age_restart, age_en;
  logic [TICK_W-1:0] age [NAGE];

  assign age_restart = {win_end, data_chg, addr_chg, sel_rise, win_start};
  assign age_en      = {1'b1, 1'b1, 1'b1, sel, win};

  for (genvar i = 0; i < NAGE; i++) begin : g_age
    sram_mon_age #(.W(TICK_W), .RST_FULL(FULL_MASK[i])) u_age (
      .clk_i, .rst_ni,
      .restart_i(age_restart[i]),
      .en_i     (age_en[i]),
      .cnt_o    (age[i])
    );
  end

  // tick distances, with a same-tick edge counted as 0
  logic [TICK_W-1:0] setup_ticks, data_ticks, rec_ticks;
  assign setup_ticks = addr_chg ? '0 : age[2];
  assign data_ticks  = data_chg ? '0 : age[3];
  assign rec_ticks   = win_end  ? '0 : age[4];

  logic [NRULE-1:0] hit;
  assign hit[0] = win_end   & below(age[0], LIM_WP);
  assign hit[1] = win_end   & below(age[1], LIM_CW);
  assign hit[2] = win_start & below(setup_ticks, LIM_AS);
  assign hit[3] = win_end   & below(data_ticks, LIM_DW);
  assign hit[4] = addr_chg  & ~win & below(rec_ticks, LIM_WR);
  assign hit[5] = addr_chg  & sel & below(age[2], LIM_RC);
  assign hit[6] = addr_chg  & win & win_q;

  viol_code_e hit_code;
  always_comb begin
    hit_code = CODE_NONE;
    for (int k = NRULE - 1; k >= 0; k--) begin
      if (hit[k]) hit_code = viol_code_e'(3'(k + 1));
    end
  end

  logic [NRULE-1:0] viol_q;
  viol_code_e       first_q;
  logic             first_v;
  logic [CNT_W-1:0] wr_cnt, rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q  <= '0;
      first_q <= CODE_NONE;
      first_v <= 1'b0;
    end else if (clr_i) begin
      viol_q  <= '0;
      first_q <= CODE_NONE;
      first_v <= 1'b0;
    end else begin
      viol_q <= viol_q | hit;
      if (!first_v && |hit) begin
        first_v <= 1'b1;
        first_q <= hit_code;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (win_end) wr_cnt <= wr_cnt + CNT_W'(1);
      if (rd_end)  rd_cnt <= rd_cnt + CNT_W'(1);
    end
  end

  assign viol_o        = viol_q;
  assign first_code_o  = first_q;
  assign first_valid_o = first_v;
  assign wr_count_o    = wr_cnt;
  assign rd_count_o    = rd_cnt;
endmodule

// File: rtl/sram_mon_chk.sv
module sram_mon_chk #(
  parameter int unsigned NR    = 7,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [NR-1:0]    viol_o,
  input logic [2:0]       first_code_o,
  input logic             first_valid_o,
  input logic [CNT_W-1:0] wr_count_o,
  input logic [CNT_W-1:0] rd_count_o
);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (viol_o == '0 && !first_valid_o));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_valid_o && !clr_i) |=> (first_valid_o && $stable(first_code_o)));

  a_r11_valid_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o == (viol_o != '0));

  a_r11_code_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_valid_o |-> (first_code_o != 3'd0 && viol_o[3'(first_code_o - 3'd1)]));

  a_r2_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (wr_count_o == $past(wr_count_o) ||
              wr_count_o == $past(wr_count_o) + CNT_W'(1)));

  a_r12_rd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_count_o == $past(rd_count_o) ||
              rd_count_o == $past(rd_count_o) + CNT_W'(1)));
endmodule

bind sram_timing_monitor sram_mon_chk #(.NR(sram_mon_pkg::NRULE), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .viol_o       (viol_o),
  .first_code_o (first_code_o),
  .first_valid_o(first_valid_o),
  .wr_count_o   (wr_count_o),
  .rd_count_o   (rd_count_o)
);

// File: tb/sram_timing_monitor_test.sv
module sram_timing_monitor_test;
  localparam int AW = 4, DW = 4, CW = 16;
  localparam int L_WP = 4, L_CW = 5, L_AS = 2, L_DW = 3, L_WR = 2, L_RC = 6;

  logic clk = 1'b0, rst_ni = 1'b0, clr_i = 1'b0;
  logic sel_n_i = 1'b1, sel_i = 1'b0, wr_en_n_i = 1'b1, out_en_n_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [6:0]    viol_o;
  logic [2:0]    first_code_o;
  logic          first_valid_o;
  logic [CW-1:0] wr_count_o, rd_count_o;

  int n_chk = 0, n_fail = 0, n_wr = 0;

  always #4 clk = ~clk;

  sram_timing_monitor #(
    .ADDR_W(AW), .DATA_W(DW), .TICK_W(8), .CNT_W(CW),
    .T_WP(L_WP), .T_CW(L_CW), .T_AS(L_AS), .T_DW(L_DW), .T_WR(L_WR), .T_RC(L_RC)
  ) uut (
    .clk_i(clk), .rst_ni, .clr_i, .sel_n_i, .sel_i, .wr_en_n_i, .out_en_n_i,
    .addr_i, .data_i, .viol_o, .first_code_o, .first_valid_o, .wr_count_o, .rd_count_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lowest(input logic [6:0] m);
    for (int k = 0; k < 7; k++) if (m[k]) return k + 1;
    return 0;
  endfunction

  task automatic check_flags(input logic [6:0] exp_v, input int exp_code);
    string tags [7] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9"};
    for (int k = 0; k < 7; k++) check(tags[k], int'(viol_o[k]), int'(exp_v[k]));
    check("R11 first code", int'(first_code_o), exp_code);
    check("R11 first valid", int'(first_valid_o), int'(exp_v != 0));
  endtask

  task automatic clear_flags();
    clr_i = 1'b1;
    ticks(1);
    clr_i = 1'b0;
    ticks(1);
    check("R10 clear", int'(viol_o), 0);
  endtask

  // write opened by write enable: select+address at t=0, window [a, a+p),
  // data change d ticks before close, address change r ticks after close
  task automatic write_we(input int a, input int p, input int d, input int r);
    for (int t = 0; t <= a + p + r + 1; t++) begin
      if (t == 0) begin addr_i = addr_i + 1'b1; sel_n_i = 1'b0; sel_i = 1'b1; end
      if (t == a) wr_en_n_i = 1'b0;
      if (t == a + p) wr_en_n_i = 1'b1;
      if (t == a + p - d) data_i = data_i + 1'b1;
      if (t == a + p + r) addr_i = addr_i + 1'b1;
      if (t == a + p + r + 1) begin sel_n_i = 1'b1; sel_i = 1'b0; end
      ticks(1);
    end
    n_wr++;
    ticks(10);
  endtask

  // write opened and closed by the active-high select
  task automatic write_sel(input int p);
    wr_en_n_i = 1'b0;
    addr_i = addr_i + 1'b1;
    ticks(3);
    sel_n_i = 1'b0; sel_i = 1'b1;
    ticks(p);
    sel_i = 1'b0;
    ticks(1);
    sel_n_i = 1'b1; wr_en_n_i = 1'b1;
    n_wr++;
    ticks(10);
  endtask

  initial begin
    logic [6:0] e, end_m, late_m;
    int code;
    ticks(3);
    rst_ni = 1'b1;
    ticks(2);
    // R1 reset state
    check("R1 flags", int'(viol_o), 0);
    check("R1 valid", int'(first_valid_o), 0);
    check("R1 wr count", int'(wr_count_o), 0);
    check("R1 rd count", int'(rd_count_o), 0);

    // R12 reads
    for (int i = 0; i < 5; i++) begin
      sel_n_i = 1'b0; sel_i = 1'b1;
      ticks(1);
      out_en_n_i = 1'b0;
      ticks(3);
      out_en_n_i = 1'b1;
      ticks(1);
      sel_n_i = 1'b1; sel_i = 1'b0;
      ticks(2);
    end
    ticks(6);
    check("R12 rd count", int'(rd_count_o), 5);
    check("R12 no flag on reads", int'(viol_o), 0);
    check("R2 no write counted", int'(wr_count_o), 0);

    // sweep of write-enable driven writes
    for (int a = 0; a <= 2; a++)
      for (int p = 2; p <= 5; p++)
        for (int d = 0; d <= ((p < 3) ? p : 3); d++)
          for (int r = 0; r <= 2; r++) begin
            write_we(a, p, d, r);
            e = '0;
            e[0] = p < L_WP;
            e[1] = (a + p) < L_CW;
            e[2] = a < L_AS;
            e[3] = d < L_DW;
            e[4] = r < L_WR;
            e[5] = (a + p + r) < L_RC;
            end_m  = e & 7'b0001011;
            late_m = e & 7'b0110000;
            if (r == 0) end_m = end_m | late_m;
            if (e[2])             code = 3;
            else if (end_m != 0)  code = lowest(end_m);
            else                  code = lowest(late_m);
            check_flags(e, code);
            clear_flags();
          end

    // R2 select-controlled windows
    write_sel(5);
    check_flags(7'b0000000, 0);
    clear_flags();
    write_sel(3);
    check_flags(7'b0000011, 1);
    clear_flags();

    // R9 address change inside an open window
    sel_n_i = 1'b0; sel_i = 1'b1;
    wr_en_n_i = 1'b0;
    ticks(3);
    addr_i = addr_i + 1'b1;
    ticks(3);
    wr_en_n_i = 1'b1;
    ticks(1);
    sel_n_i = 1'b1; sel_i = 1'b0;
    n_wr++;
    ticks(10);
    check_flags(7'b1000000, 7);
    ticks(20);
    check("R10 sticky", int'(viol_o), 7'b1000000);
    clear_flags();

    check("R2 wr count", int'(wr_count_o), n_wr);
    check("R12 rd count unchanged", int'(rd_count_o), 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule